// File: doc/BRIEF.md
# Power-of-Two Multiply Shifter and Rotator

This block shifts or rotates a 32-bit word by an amount from 0 to 31. It uses a single wide multiplication instead of a tree of multiplexers. The data word is multiplied by a power of two, which gives a product of twice the data width. The result is then taken from one half of that product, or from both halves combined.

- A left shift multiplies by 2^N and keeps the low half.
- A right shift multiplies by 2^(W-N) and keeps the high half.
- A rotate ORs the two halves of the 2^N product together.

The multiplier sees the data as signed or unsigned, and this alone decides whether a right shift fills with the sign bit or with zeros. There is no separate fill multiplexer.

The caller presents the data, the amount and three control flags together with a valid strobe. The result appears on a registered output one clock later, alongside a registered valid.

Top module: `mulshift_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_vld` is 0 and `res_word` is all zeros.
- R2: `res_vld` equals the value `src_vld` had at the previous rising clock edge. A result is presented exactly one cycle after its request.
- R3: With `op_rot`=0 and `op_rgt`=0, the result is the data shifted left by `src_amt`, with zeros entering at the bottom. `op_sgn` has no effect on this result.
- R4: With `op_rot`=0, `op_rgt`=1 and `op_sgn`=0, the result is the data shifted right by `src_amt`, with zeros entering at the most significant end.
- R5: With `op_rot`=0, `op_rgt`=1 and `op_sgn`=1, the result is the data shifted right by `src_amt`, with copies of data bit 31 entering at the most significant end.
- R6: With `op_rot`=1, the result is the data rotated left by `src_amt`. Bit i of the data moves to bit (i+N) mod 32. `op_rgt` and `op_sgn` have no effect on this result.
- R7: A right shift (R4 or R5) with `src_amt`=0 returns the data unchanged.
- R8: A cycle with `src_vld`=0 leaves `res_word` holding its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_vld | input | 1 | Request strobe for the current cycle |
| src_word | input | 32 | Data word to shift or rotate |
| src_amt | input | 5 | Shift or rotate amount N |
| op_rot | input | 1 | 1 selects rotate left; takes priority over the other flags |
| op_rgt | input | 1 | 1 selects a right shift when not rotating |
| op_sgn | input | 1 | 1 treats the data as signed for a right shift |
| res_vld | output | 1 | Registered copy of the request strobe |
| res_word | output | 32 | Registered result |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a 5-bit amount. With these, every amount from 0 to 31 can be reached, including the zero-amount right shift that bypasses the product and the amount of 31, where the multiplier is 2^1.

The data patterns are chosen so that every operation is checked with both a set and a clear top bit. This makes the sign fill distinguishable from the zero fill. It also shows whether bits crossing the product halves during a rotate are lost or duplicated.

// File: rtl/mulshift_pkg.sv
package mulshift_pkg;

  typedef enum logic [1:0] {
    SH_LEFT = 2'd0,
    SH_RLOG = 2'd1,
    SH_RARI = 2'd2,
    SH_ROTL = 2'd3
  } shop_e;

  function automatic shop_e pick_op(input logic rot, input logic rgt, input logic sgn);
    if (rot)      return SH_ROTL;
    else if (!rgt) return SH_LEFT;
    else if (sgn)  return SH_RARI;
    else           return SH_RLOG;
  endfunction

endpackage

// File: rtl/mulshift_decode.sv
module mulshift_decode
  import mulshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              rot,
  input  logic              rgt,
  input  logic              sgn,
  input  logic [AMT_W-1:0]  amt,
  output shop_e             op,
  output logic [DATA_W-1:0] factor,
  output logic              bypass,
  output logic              sext
);
  localparam logic [AMT_W:0] FULL_EXP = (AMT_W+1)'(DATA_W);

  function automatic logic [DATA_W-1:0] pow_two(input logic [AMT_W:0] e);
    logic [DATA_W-1:0] p;
    p = '0;
    if (e < FULL_EXP) p = DATA_W'(1) << e;
    return p;
  endfunction

  function automatic logic [AMT_W:0] exponent(input shop_e o, input logic [AMT_W-1:0] n);
    if (o == SH_RLOG || o == SH_RARI) return FULL_EXP - {1'b0, n};
    else                              return {1'b0, n};
  endfunction

  always_comb begin
    op     = pick_op(rot, rgt, sgn);
    factor = pow_two(exponent(op, amt));
    bypass = (op == SH_RLOG || op == SH_RARI) && (amt == '0);
    sext   = (op == SH_RARI);
  end

endmodule

// File: rtl/mulshift_mult.sv
module mulshift_mult #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   data,
  input  logic [DATA_W-1:0]   factor,
  input  logic                sext,
  output logic [2*DATA_W-1:0] prod
);
  function automatic logic [2*DATA_W-1:0] widen(input logic [DATA_W-1:0] d, input logic s);
    return {{DATA_W{s & d[DATA_W-1]}}, d};
  endfunction

  logic [2*DATA_W-1:0] a_ext;
  logic [2*DATA_W-1:0] b_ext;

  always_comb begin
    a_ext = widen(data, sext);
    b_ext = {{DATA_W{1'b0}}, factor};
    prod  = a_ext * b_ext;
  end

endmodule

// File: rtl/mulshift_select.sv
module mulshift_select
  import mulshift_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  shop_e               op,
  input  logic                bypass,
  input  logic [DATA_W-1:0]   data,
  input  logic [2*DATA_W-1:0] prod,
  output logic [DATA_W-1:0]   result
);
  logic [DATA_W-1:0] lo_half;
  logic [DATA_W-1:0] hi_half;
  logic [DATA_W-1:0] wrapped;

  assign lo_half = prod[DATA_W-1:0];
  assign hi_half = prod[2*DATA_W-1:DATA_W];

  for (genvar i = 0; i < DATA_W; i++) begin : g_merge
    assign wrapped[i] = lo_half[i] | hi_half[i];
  end

  always_comb begin
    unique case (op)
      SH_LEFT:          result = lo_half;
      SH_RLOG, SH_RARI: result = bypass ? data : hi_half;
      SH_ROTL:          result = wrapped;
      default:          result = lo_half;
    endcase
  end

endmodule

// File: rtl/mulshift_unit.sv
module mulshift_unit
  import mulshift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_vld,
  input  logic [DATA_W-1:0] src_word,
  input  logic [AMT_W-1:0]  src_amt,
  input  logic              op_rot,
  input  logic              op_rgt,
  input  logic              op_sgn,
  output logic              res_vld,
  output logic [DATA_W-1:0] res_word
);
  shop_e               dec_op;
  logic [DATA_W-1:0]   dec_factor;
  logic                dec_bypass;
  logic                dec_sext;
  logic [2*DATA_W-1:0] mul_prod;
  logic [DATA_W-1:0]   sel_result;

  mulshift_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_dec (
    .rot(op_rot), .rgt(op_rgt), .sgn(op_sgn), .amt(src_amt),
    .op(dec_op), .factor(dec_factor), .bypass(dec_bypass), .sext(dec_sext)
  );

  mulshift_mult #(.DATA_W(DATA_W)) u_mul (
    .data(src_word), .factor(dec_factor), .sext(dec_sext), .prod(mul_prod)
  );

  mulshift_select #(.DATA_W(DATA_W)) u_sel (
    .op(dec_op), .bypass(dec_bypass), .data(src_word), .prod(mul_prod),
    .result(sel_result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      res_word <= '0;
    end else begin
      res_vld <= src_vld;
      if (src_vld) res_word <= sel_result;
    end
  end

  function automatic logic [DATA_W-1:0] low_mask(input logic [AMT_W-1:0] n);
    return (DATA_W'(1) << n) - DATA_W'(1);
  endfunction

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    src_vld |=> res_vld);
  p_valid_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !src_vld |=> !res_vld);
  p_factor_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_vld && !dec_bypass) |-> ($countones(dec_factor) == 1));
  p_left_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src_vld && dec_op == SH_LEFT) |=> ((res_word & low_mask($past(src_amt))) == '0));
  p_lsr_top_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_vld && dec_op == SH_RLOG && src_amt != '0) |=> !res_word[DATA_W-1]);
  p_asr_top_sign_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_vld && dec_op == SH_RARI) |=> (res_word[DATA_W-1] == $past(src_word[DATA_W-1])));
  p_rot_bitcount_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_vld && dec_op == SH_ROTL) |=> ($countones(res_word) == $countones($past(src_word))));
  p_zero_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_vld && op_rgt && !op_rot && src_amt == '0) |=> (res_word == $past(src_word)));
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !src_vld |=> $stable(res_word));

endmodule

// File: tb/sim_mulshift_unit.sv
module sim_mulshift_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         src_vld = 1'b0;
  logic [W-1:0] src_word = '0;
  logic [4:0]   src_amt = '0;
  logic         op_rot = 1'b0, op_rgt = 1'b0, op_sgn = 1'b0;
  logic         res_vld;
  logic [W-1:0] res_word;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mulshift_unit u0 (
    .clk(clk), .rst_n(rst_n), .src_vld(src_vld), .src_word(src_word),
    .src_amt(src_amt), .op_rot(op_rot), .op_rgt(op_rgt), .op_sgn(op_sgn),
    .res_vld(res_vld), .res_word(res_word)
  );

  function automatic logic [W-1:0] expect_val(input logic [W-1:0] d, input int n,
                                              input bit rot, input bit rgt, input bit sgn);
    logic [W-1:0] r;
    if (rot) begin
      r = d;
      for (int k = 0; k < n; k++) r = {r[W-2:0], r[W-1]};
    end else if (!rgt) r = d << n;
    else if (sgn)      r = W'($signed(d) >>> n);
    else               r = d >> n;
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [W-1:0] d, input int n,
                        input bit rot, input bit rgt, input bit sgn);
    @(negedge clk);
    src_word = d; src_amt = 5'(n); op_rot = rot; op_rgt = rgt; op_sgn = sgn;
    src_vld = 1'b1;
    @(negedge clk);
    src_vld = 1'b0;
    check(req, res_word, expect_val(d, n, rot, rgt, sgn));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid", {31'd0, res_vld}, '0);
    check("R1 data", res_word, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {31'd0, res_vld}, '0);
  endtask

  task automatic t_left();
    run_op("R3 lsl", 32'h0000_00F1, 4, 0, 0, 0);
    run_op("R3 lsl msb", 32'h8765_4321, 31, 0, 0, 0);
    run_op("R3 sign flag ignored", 32'hF000_000F, 8, 0, 0, 1);
    run_op("R3 amount zero", 32'hDEAD_BEEF, 0, 0, 0, 0);
  endtask

  task automatic t_lsr();
    run_op("R4 lsr neg", 32'hF000_1234, 4, 0, 1, 0);
    run_op("R4 lsr max", 32'h8000_0000, 31, 0, 1, 0);
    run_op("R4 lsr pos", 32'h7ABC_DEF0, 13, 0, 1, 0);
  endtask

  task automatic t_asr();
    run_op("R5 asr neg", 32'hF000_1234, 4, 0, 1, 1);
    run_op("R5 asr max", 32'h8000_0000, 31, 0, 1, 1);
    run_op("R5 asr pos", 32'h7ABC_DEF0, 13, 0, 1, 1);
    run_op("R5 asr one", 32'hA5A5_A5A5, 1, 0, 1, 1);
  endtask

  task automatic t_rot();
    run_op("R6 rot", 32'h8000_0001, 1, 1, 0, 0);
    run_op("R6 rot flags ignored", 32'h1234_5678, 12, 1, 1, 1);
    run_op("R6 rot max", 32'hC000_0003, 31, 1, 0, 1);
    run_op("R6 rot zero", 32'hCAFE_F00D, 0, 1, 1, 0);
  endtask

  task automatic t_zero_right();
    run_op("R7 lsr zero", 32'h9ABC_DEF0, 0, 0, 1, 0);
    run_op("R7 asr zero", 32'h8000_0001, 0, 0, 1, 1);
  endtask

  task automatic t_latency_hold();
    logic [W-1:0] keep;
    run_op("R2 pulse data", 32'h0000_0003, 2, 0, 0, 0);
    check("R2 valid one cycle later", {31'd0, res_vld}, 32'd1);
    keep = res_word;
    src_word = 32'hFFFF_FFFF; src_amt = 5'd7; op_rot = 1'b1;
    @(negedge clk);
    check("R2 valid drops", {31'd0, res_vld}, '0);
    check("R8 hold 1", res_word, keep);
    src_word = 32'h0F0F_0F0F;
    @(negedge clk);
    check("R8 hold 2", res_word, keep);
  endtask

  initial begin
    t_reset();
    t_left();
    t_lsr();
    t_asr();
    t_rot();
    t_zero_right();
    t_latency_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule